// File: doc/BRIEF.md
# Voltage and Clock-Divisor Sequencer for Tiled Core Domains

This block manages the supply level and the per-tile clock divisors for a set of voltage domains. Each domain has four tiles, and each tile is one clock domain of two cores. Every core asks for a clock divisor of a fixed 1600 MHz reference. The block turns those requests into one divisor per tile and one supply-level code per domain, following a policy chosen for each domain. The block runs inside the power-management path of a many-core chip. Software writes the requests, and the divisor and level outputs drive the clock generators and the regulator interface.

Divisor and supply changes are put in a safe order. A tile never runs faster than the present supply allows. When the supply must drop, the divisors move first. When it must rise, the supply step finishes before any divisor gets smaller. Only one domain at a time may step its supply, and a round-robin arbiter picks which. While a domain steps, the clocks of its tiles stop for a programmable settle interval, and its busy flag stays high for that interval. New requests that arrive during the step are applied once the clocks resume.

Top module: `vfs_dvfs_top`

## Requirements
- R1: Each raw 5-bit core request is taken as a divisor clamped into 2..16 (0 and 1 become 2, 17..31 become 16). Every tile divisor output always lies in 2..16.
- R2: With policy bit 0 (per-tile), once settled, tile t's divisor is the smaller of the clamped requests of its cores 2t and 2t+1. Core c of domain d is at bits [(d*8+c)*5 +: 5].
- R3: With policy bit 1 (all-high), once settled, every tile of the domain takes the smallest clamped request among the domain's eight cores.
- R4: The 2-bit level code for a divisor is 3 for divisor 2, 2 for divisor 3, 1 for divisor 4, and 0 for 5..16. Once settled, a domain's level output is the largest code over its tiles.
- R5: In every cycle, each tile's divisor needs a level code no higher than its domain's present level output.
- R6: At most one domain is busy in any cycle. Domains that request a step in the same cycle are all served, one after another.
- R7: A supply step keeps the domain's busy flag high for exactly max(settle_cycles,1) cycles. The four clock-stop outputs of the domain's tiles (bit d*4+t) equal the domain's busy flag.
- R8: A tile divisor does not change in the cycle after one in which its domain is busy. A request that changes during a step is applied after the step ends.
- R9: While reset is asserted, every tile divisor is 16, every level code is 3, and no busy or clock-stop output is high.
- R10: A domain's level output changes only in a cycle where that domain's busy flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle_cycles | input | CNT_W | Supply settle interval in cycles |
| policy_all_high | input | NUM_DOM | Per-domain policy, 1 = all-high, 0 = per-tile |
| core_div_req | input | NUM_DOM*TILES*CPT*5 | Raw per-core divisor requests |
| tile_div | output | NUM_DOM*TILES*5 | Applied divisor per tile |
| vlevel | output | NUM_DOM*2 | Supply level code per domain |
| clk_stop | output | NUM_DOM*TILES | Clock stop per tile |
| busy | output | NUM_DOM | Supply step in progress per domain |

## Verification
Two events can land in the same cycle. The first is two domains asking for a supply step at once, provoked by raising both domains' requests in one cycle. It is judged by counting each domain's busy cycles, which must total one settle interval each with no overlap. The second is a request change that arrives while a step is running, provoked by rewriting a domain's requests just after its busy flag rises. It is judged by checking that the divisors stay frozen until busy falls and then settle to the new request. A per-cycle monitor checks the frequency-under-level invariant throughout.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
    localparam int DIV_W = 5;
    localparam int LVL_W = 2;
    localparam logic [DIV_W-1:0] DIV_MIN = 5'd2;
    localparam logic [DIV_W-1:0] DIV_MAX = 5'd16;
    // largest divisor still needing each level code
    localparam logic [DIV_W-1:0] DIV_NEEDS_L3 = 5'd2;
    localparam logic [DIV_W-1:0] DIV_NEEDS_L2 = 5'd3;
    localparam logic [DIV_W-1:0] DIV_NEEDS_L1 = 5'd4;
    localparam logic [LVL_W-1:0] LVL_TOP = 2'd3;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] raw);
        if (raw < DIV_MIN)      return DIV_MIN;
        else if (raw > DIV_MAX) return DIV_MAX;
        else                    return raw;
    endfunction

    function automatic logic [LVL_W-1:0] lvl_for_div(input logic [DIV_W-1:0] d);
        if (d <= DIV_NEEDS_L3)      return 2'd3;
        else if (d <= DIV_NEEDS_L2) return 2'd2;
        else if (d <= DIV_NEEDS_L1) return 2'd1;
        else                        return 2'd0;
    endfunction
endpackage

// File: rtl/vfs_target_calc.sv
module vfs_target_calc
    import vfs_pkg::*;
#(
    parameter int TILES = 4,
    parameter int CPT   = 2
) (
    input  logic [TILES*CPT*DIV_W-1:0]  core_req,
    input  logic                        all_high,
    output logic [TILES-1:0][DIV_W-1:0] tgt_div,
    output logic [LVL_W-1:0]            tgt_lvl
);
    localparam int CORES = TILES * CPT;

    logic [CORES-1:0][DIV_W-1:0] clamped;
    logic [TILES-1:0][DIV_W-1:0] tile_min;
    logic [DIV_W-1:0]            dom_min;

    for (genvar c = 0; c < CORES; c++) begin : g_clamp
        assign clamped[c] = clamp_div(core_req[c*DIV_W +: DIV_W]);
    end

    always_comb begin
        dom_min = DIV_MAX;
        for (int t = 0; t < TILES; t++) begin
            tile_min[t] = DIV_MAX;
            for (int k = 0; k < CPT; k++) begin
                if (clamped[t*CPT+k] < tile_min[t]) tile_min[t] = clamped[t*CPT+k];
            end
            if (tile_min[t] < dom_min) dom_min = tile_min[t];
        end
    end

    always_comb begin
        tgt_lvl = '0;
        for (int t = 0; t < TILES; t++) begin
            tgt_div[t] = all_high ? dom_min : tile_min[t];
            if (lvl_for_div(tgt_div[t]) > tgt_lvl) tgt_lvl = lvl_for_div(tgt_div[t]);
        end
    end
endmodule

// File: rtl/vfs_domain_seq.sv
module vfs_domain_seq
    import vfs_pkg::*;
#(
    parameter int TILES = 4,
    parameter int CNT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TILES-1:0][DIV_W-1:0] tgt_div,
    input  logic [LVL_W-1:0]            tgt_lvl,
    input  logic [CNT_W-1:0]            settle,
    input  logic                        gnt,
    output logic                        req,
    output logic                        done,
    output logic                        busy,
    output logic [LVL_W-1:0]            lvl,
    output logic [TILES-1:0][DIV_W-1:0] div
);
    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_STEP} seq_st_e;

    typedef struct packed {
        seq_st_e                     st;
        logic [LVL_W-1:0]            lvl;
        logic [LVL_W-1:0]            pend;
        logic [CNT_W-1:0]            cnt;
        logic [TILES-1:0][DIV_W-1:0] div;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        req   = 1'b0;
        done  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (tgt_lvl == seq_q.lvl) begin
                    seq_d.div = tgt_div;
                end else if (tgt_lvl < seq_q.lvl) begin
                    // slow the tiles first, then drop the supply
                    seq_d.div  = tgt_div;
                    seq_d.pend = tgt_lvl;
                    seq_d.st   = ST_REQ;
                end else begin
                    // only slow-downs now; speed-ups wait for the supply
                    for (int t = 0; t < TILES; t++) begin
                        seq_d.div[t] = (tgt_div[t] > seq_q.div[t]) ? tgt_div[t] : seq_q.div[t];
                    end
                    seq_d.pend = tgt_lvl;
                    seq_d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                req = 1'b1;
                if (gnt) begin
                    seq_d.st  = ST_STEP;
                    seq_d.lvl = seq_q.pend;
                    seq_d.cnt = settle;
                end
            end
            ST_STEP: begin
                if (seq_q.cnt <= CNT_W'(1)) begin
                    done      = 1'b1;
                    seq_d.cnt = '0;
                    seq_d.st  = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.lvl  <= LVL_TOP;
            seq_q.pend <= LVL_TOP;
            seq_q.cnt  <= '0;
            for (int t = 0; t < TILES; t++) seq_q.div[t] <= DIV_MAX;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.st == ST_STEP);
    assign lvl  = seq_q.lvl;
    assign div  = seq_q.div;
endmodule

// File: rtl/vfs_volt_arbiter.sv
module vfs_volt_arbiter #(
    parameter int NUM_DOM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] req,
    input  logic [NUM_DOM-1:0] done,
    output logic [NUM_DOM-1:0] gnt
);
    localparam int IDX_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] ptr;
    } arb_t;

    arb_t arb_d, arb_q;
    logic found;

    always_comb begin
        arb_d = arb_q;
        gnt   = '0;
        found = 1'b0;
        if (arb_q.active) begin
            if (|done) arb_d.active = 1'b0;
        end else begin
            for (int i = 0; i < NUM_DOM; i++) begin
                for (int j = 0; j < NUM_DOM; j++) begin
                    if (!found && req[j] && (j == ((int'(arb_q.ptr) + i) % NUM_DOM))) begin
                        found        = 1'b1;
                        gnt[j]       = 1'b1;
                        arb_d.active = 1'b1;
                        arb_d.ptr    = IDX_W'((j + 1) % NUM_DOM);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end
endmodule

// File: rtl/vfs_dvfs_top.sv
module vfs_dvfs_top
    import vfs_pkg::*;
#(
    parameter int NUM_DOM = 2,
    parameter int TILES   = 4,
    parameter int CPT     = 2,
    parameter int CNT_W   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CNT_W-1:0]                 settle_cycles,
    input  logic [NUM_DOM-1:0]               policy_all_high,
    input  logic [NUM_DOM*TILES*CPT*DIV_W-1:0] core_div_req,
    output logic [NUM_DOM*TILES*DIV_W-1:0]   tile_div,
    output logic [NUM_DOM*LVL_W-1:0]         vlevel,
    output logic [NUM_DOM*TILES-1:0]         clk_stop,
    output logic [NUM_DOM-1:0]               busy
);
    localparam int REQ_SLICE = TILES * CPT * DIV_W;
    localparam int DIV_SLICE = TILES * DIV_W;

    logic [NUM_DOM-1:0] step_req, step_gnt, step_done;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic [TILES-1:0][DIV_W-1:0] tgt_div, cur_div;
        logic [LVL_W-1:0]            tgt_lvl, cur_lvl;

        vfs_target_calc #(.TILES(TILES), .CPT(CPT)) i_calc (
            .core_req (core_div_req[d*REQ_SLICE +: REQ_SLICE]),
            .all_high (policy_all_high[d]),
            .tgt_div  (tgt_div),
            .tgt_lvl  (tgt_lvl)
        );

        vfs_domain_seq #(.TILES(TILES), .CNT_W(CNT_W)) i_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .tgt_div (tgt_div),
            .tgt_lvl (tgt_lvl),
            .settle  (settle_cycles),
            .gnt     (step_gnt[d]),
            .req     (step_req[d]),
            .done    (step_done[d]),
            .busy    (busy[d]),
            .lvl     (cur_lvl),
            .div     (cur_div)
        );

        assign tile_div[d*DIV_SLICE +: DIV_SLICE] = cur_div;
        assign vlevel[d*LVL_W +: LVL_W]           = cur_lvl;
        assign clk_stop[d*TILES +: TILES]         = {TILES{busy[d]}};
    end

    vfs_volt_arbiter #(.NUM_DOM(NUM_DOM)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (step_req),
        .done  (step_done),
        .gnt   (step_gnt)
    );
endmodule

// File: rtl/vfs_dvfs_chk.sv
module vfs_dvfs_chk
    import vfs_pkg::*;
#(
    parameter int NUM_DOM = 2,
    parameter int TILES   = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_DOM*TILES*DIV_W-1:0] tile_div,
    input logic [NUM_DOM*LVL_W-1:0]       vlevel,
    input logic [NUM_DOM*TILES-1:0]       clk_stop,
    input logic [NUM_DOM-1:0]             busy
);
    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_d
        assert_level_moves_in_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(vlevel[d*LVL_W +: LVL_W]) |-> busy[d]);

        assert_div_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
            busy[d] |=> $stable(tile_div[d*TILES*DIV_W +: TILES*DIV_W]));

        for (genvar t = 0; t < TILES; t++) begin : g_t
            assert_freq_under_volt_R5: assert property (@(posedge clk) disable iff (!rst_n)
                lvl_for_div(tile_div[(d*TILES+t)*DIV_W +: DIV_W]) <= vlevel[d*LVL_W +: LVL_W]);

            assert_div_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (tile_div[(d*TILES+t)*DIV_W +: DIV_W] >= DIV_MIN) &&
                (tile_div[(d*TILES+t)*DIV_W +: DIV_W] <= DIV_MAX));

            assert_stop_tracks_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
                clk_stop[d*TILES+t] == busy[d]);
        end
    end
endmodule

bind vfs_dvfs_top vfs_dvfs_chk #(.NUM_DOM(NUM_DOM), .TILES(TILES)) i_vfs_dvfs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tile_div (tile_div),
    .vlevel   (vlevel),
    .clk_stop (clk_stop),
    .busy     (busy)
);

// File: tb/test_vfs_dvfs_top.sv
module test_vfs_dvfs_top;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 2;
    localparam int NT = 4;
    localparam int NC = 2;
    localparam int DW = 5;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic                   rst_n;
    logic [CW-1:0]          settle_cycles;
    logic [ND-1:0]          policy_all_high;
    logic [ND*NT*NC*DW-1:0] core_div_req;
    logic [ND*NT*DW-1:0]    tile_div;
    logic [ND*2-1:0]        vlevel;
    logic [ND*NT-1:0]       clk_stop;
    logic [ND-1:0]          busy;

    vfs_dvfs_top #(.NUM_DOM(ND), .TILES(NT), .CPT(NC), .CNT_W(CW)) i_vfs_dvfs_top (
        .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles),
        .policy_all_high(policy_all_high), .core_div_req(core_div_req),
        .tile_div(tile_div), .vlevel(vlevel), .clk_stop(clk_stop), .busy(busy)
    );

    int errors = 0;
    int checks = 0;
    bit mon_on = 0;

    function automatic int ex_clamp(int raw);
        return (raw < 2) ? 2 : ((raw > 16) ? 16 : raw);
    endfunction

    function automatic int ex_lvl(int dv);
        return (dv == 2) ? 3 : (dv == 3) ? 2 : (dv == 4) ? 1 : 0;
    endfunction

    function automatic int get_req(int d, int c);
        return int'(core_div_req[(d*NT*NC+c)*DW +: DW]);
    endfunction

    function automatic int get_tile(int d, int t);
        return int'(tile_div[(d*NT+t)*DW +: DW]);
    endfunction

    task automatic check_eq(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic set_core(int d, int c, int v);
        core_div_req[(d*NT*NC+c)*DW +: DW] = DW'(v);
    endtask

    task automatic set_dom(int d, int v);
        for (int c = 0; c < NT*NC; c++) set_core(d, c, v);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // expected settled outputs of one domain, from the current requests
    task automatic check_settled(int d, string tile_tag);
        int tmin[NT];
        int dmin;
        int lvl;
        dmin = 16;
        for (int t = 0; t < NT; t++) begin
            tmin[t] = 16;
            for (int k = 0; k < NC; k++) begin
                if (ex_clamp(get_req(d, t*NC+k)) < tmin[t]) tmin[t] = ex_clamp(get_req(d, t*NC+k));
            end
            if (tmin[t] < dmin) dmin = tmin[t];
        end
        lvl = 0;
        for (int t = 0; t < NT; t++) begin
            int e;
            e = policy_all_high[d] ? dmin : tmin[t];
            check_eq(tile_tag, $sformatf("dom%0d tile%0d divisor", d, t), get_tile(d, t), e);
            if (ex_lvl(e) > lvl) lvl = ex_lvl(e);
        end
        check_eq("R4", $sformatf("dom%0d level", d), int'(vlevel[d*2 +: 2]), lvl);
        check_eq("R6", $sformatf("dom%0d idle after settle", d), int'(busy[d]), 0);
    endtask

    // per-cycle monitor
    int  prev_lvl [ND];
    int  prev_div [ND][NT];
    bit  prev_busy[ND];
    bit  prev_ok = 0;
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            check_eq("R6", "domains busy together", ($countones(busy) > 1) ? 1 : 0, 0);
            for (int d = 0; d < ND; d++) begin
                for (int t = 0; t < NT; t++) begin
                    if (ex_lvl(get_tile(d, t)) > int'(vlevel[d*2 +: 2]))
                        check_eq("R5", $sformatf("dom%0d tile%0d needs level", d, t),
                                 ex_lvl(get_tile(d, t)), int'(vlevel[d*2 +: 2]));
                    if (clk_stop[d*NT+t] != busy[d])
                        check_eq("R7", $sformatf("dom%0d tile%0d clk_stop", d, t),
                                 int'(clk_stop[d*NT+t]), int'(busy[d]));
                    if (prev_ok && prev_busy[d] && get_tile(d, t) != prev_div[d][t])
                        check_eq("R8", $sformatf("dom%0d tile%0d moved after busy", d, t),
                                 get_tile(d, t), prev_div[d][t]);
                end
                if (prev_ok && int'(vlevel[d*2 +: 2]) != prev_lvl[d] && !busy[d])
                    check_eq("R10", $sformatf("dom%0d level moved while not busy", d),
                             int'(vlevel[d*2 +: 2]), prev_lvl[d]);
                prev_lvl[d]  = int'(vlevel[d*2 +: 2]);
                prev_busy[d] = busy[d];
                for (int t = 0; t < NT; t++) prev_div[d][t] = get_tile(d, t);
            end
            prev_ok = 1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int n0;
        int n1;
        int both;
        bit seen;
        rst_n = 1'b0;
        settle_cycles = CW'(3);
        policy_all_high = '0;
        for (int d = 0; d < ND; d++) set_dom(d, 16);
        tick(3);
        // R9: reset state
        for (int d = 0; d < ND; d++) begin
            for (int t = 0; t < NT; t++) check_eq("R9", "reset divisor", get_tile(d, t), 16);
            check_eq("R9", "reset level", int'(vlevel[d*2 +: 2]), 3);
            check_eq("R9", "reset busy", int'(busy[d]), 0);
            check_eq("R9", "reset clk_stop", int'(clk_stop[d*NT +: NT]), 0);
        end
        rst_n = 1'b1;
        mon_on = 1;
        tick(40);
        for (int d = 0; d < ND; d++) check_settled(d, "R2");

        // R1: every raw request value, clamped
        for (int r = 0; r < 32; r++) begin
            set_dom(0, r);
            set_dom(1, 31 - r);
            tick(30);
            check_settled(0, "R1");
            check_settled(1, "R1");
        end

        // R2 and R3: every pair of core requests on a rotating tile
        for (int p = 0; p < 2; p++) begin
            policy_all_high[0] = p[0];
            for (int a = 2; a <= 16; a++) begin
                for (int b = 2; b <= 16; b++) begin
                    int k;
                    k = (a + b) % NT;
                    set_dom(0, 16);
                    set_core(0, 2*k, a);
                    set_core(0, 2*k+1, b);
                    tick(25);
                    check_settled(0, (p == 1) ? "R3" : "R2");
                end
            end
        end
        policy_all_high = '0;
        set_dom(0, 16);
        set_dom(1, 16);
        tick(40);

        // R7: busy length for settle 7 and settle 0
        settle_cycles = CW'(7);
        set_dom(0, 2);
        n0 = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (busy[0]) n0++; end
        check_eq("R7", "busy cycles, settle 7", n0, 7);
        check_settled(0, "R7");
        settle_cycles = CW'(0);
        set_dom(0, 16);
        n0 = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (busy[0]) n0++; end
        check_eq("R7", "busy cycles, settle 0", n0, 1);
        check_settled(0, "R7");

        // R6: two domains asking in the same cycle
        settle_cycles = CW'(5);
        set_dom(0, 2);
        set_dom(1, 3);
        n0 = 0; n1 = 0; both = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (busy[0]) n0++;
            if (busy[1]) n1++;
            if (busy[0] && busy[1]) both++;
        end
        check_eq("R6", "dom0 busy cycles in collision", n0, 5);
        check_eq("R6", "dom1 busy cycles in collision", n1, 5);
        check_eq("R6", "overlapping busy cycles", both, 0);
        check_settled(0, "R6");
        check_settled(1, "R6");

        // R8: request changed during a step is held, then applied
        set_dom(0, 16);
        set_dom(1, 16);
        tick(60);
        settle_cycles = CW'(10);
        set_dom(0, 4);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy[0] && !seen) begin
                seen = 1;
                break;
            end
        end
        check_eq("R8", "step started", int'(seen), 1);
        set_dom(0, 2);
        check_eq("R8", "divisor held at step start", get_tile(0, 0), 16);
        tick(5);
        check_eq("R8", "divisor held mid step", get_tile(0, 1), 16);
        check_eq("R8", "still busy mid step", int'(busy[0]), 1);
        tick(80);
        check_settled(0, "R8");

        mon_on = 0;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule